// File: doc/BRIEF.md
# Configurable Logic Block Tile

This block is one tile of a lookup-table logic fabric. Two 4-input function generators (F and G) each hold a 16-entry, 1-bit truth table. A third, 3-input generator (H) combines their outputs with an extra input. Two storage elements (X and Y) can register any generator output or a direct data input. Either 4-input generator can instead act as a 16x1 synchronous RAM. Each storage element is configured on its own as a flip-flop or a latch, with its own clock polarity and its own kind of set/reset (synchronous or asynchronous, forcing 1 or 0).

All truth tables and mode bits live in a 54-bit configuration register. It is loaded serially while `cfg_en` is high. Until a load has finished, every output of the tile is held at 0. The fabric around the tile feeds the logic inputs and uses the combinational and registered outputs.

Top module: `clb_tile`

## Requirements
- R1: While `cfg_en` is high, each rising `clk` edge shifts `cfg_din` into the top of the 54-bit configuration register, so the bit sent first ends in bit 0. Field layout: F table [15:0], G table [31:16], H table [39:32], F RAM mode [40], G RAM mode [41], X storage [47:42], Y storage [53:48]. A storage field holds, from its low bit up: latch mode, clock invert, asynchronous set/reset, set/reset value, and a 2-bit data select. While `cfg_en` is high all five outputs read 0.
- R2: Once loaded, `f_out` equals F table bit `f_in` and `g_out` equals G table bit `g_in`, combinationally.
- R3: `h_out` equals H table bit {`h1`, G output, F output}, with `h1` as the most significant index bit.
- R4: A generator in RAM mode writes `din` into its table entry addressed by its inputs on a rising `clk` edge where `we` is high. The new value reads out combinationally after that edge.
- R5: A generator in logic mode ignores `we`, and its table is not changed.
- R6: A storage element in flip-flop mode captures its selected data on its active edge when `ce` is high. It does not change before that edge, and it holds its value when `ce` is low.
- R7: With clock invert set, the active edge of a flip-flop is the falling edge of `clk`.
- R8: In latch mode with clock invert clear, the element is transparent while `clk` is high and `ce` is high, and it holds while `clk` is low.
- R9: Synchronous set/reset loads the set/reset value at the active edge (or while the latch is open) and wins over `ce` and the data.
- R10: Asynchronous set/reset of a flip-flop forces the set/reset value at once, without a clock edge.
- R11: Data select codes: 0 picks the F output, 1 picks the G output, 2 picks the H output, 3 picks `din`.
- R12: Synchronous active-low `rst_n` clears the configuration and the loaded state, so all outputs read 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration shift, RAM writes and storage |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| f_in | input | 4 | F generator inputs / RAM address |
| g_in | input | 4 | G generator inputs / RAM address |
| h1 | input | 1 | Extra input of the H generator |
| din | input | 1 | Direct data input and RAM write data |
| we | input | 1 | RAM write enable |
| ce | input | 1 | Shared clock enable of the storage elements |
| sr | input | 1 | Shared set/reset control |
| f_out | output | 1 | F generator output |
| g_out | output | 1 | G generator output |
| h_out | output | 1 | H generator output |
| xq | output | 1 | X storage output |
| yq | output | 1 | Y storage output |

## Verification
Some rules can be judged at each rising edge, and the assertions check those on every cycle. They are: the zero outputs during loading, the RAM read-after-write on F, and the synchronous set/reset and hold of X as a rising-edge flip-flop. Other behaviour lives between rising edges or needs a known truth table, and only the bench's scenarios show it. That covers falling-edge capture, latch transparency and hold across clock phases, and asynchronous set/reset acting mid-phase. It also covers data-select routing and the random table reads of F, G and H against a model.

// File: rtl/clb_pkg.sv
// Shared types for the logic block tile.
// Assumes: storage configuration fields are 6 bits wide, H table has 8 entries.
package clb_pkg;
    localparam int ST_W = 6;
    localparam int H_IN = 3;
    localparam int H_TAB = 1 << H_IN;

    typedef enum logic [1:0] {
        SEL_F   = 2'd0,
        SEL_G   = 2'd1,
        SEL_H   = 2'd2,
        SEL_DIN = 2'd3
    } dsel_e;

    typedef struct packed {
        dsel_e dsel;
        logic  sr_val;
        logic  sr_async;
        logic  clk_inv;
        logic  is_latch;
    } st_cfg_t;
endpackage

// File: rtl/clb_cfg_chain.sv
// Configuration register of the tile.
// Shifts serial data in toward bit 0 while enabled. Otherwise it applies RAM
// write strobes to the F and G table fields. Assumes strobes are already
// gated by the caller.
module clb_cfg_chain #(
    parameter int CW   = 54,
    parameter int TAB  = 16,
    parameter int OF_F = 0,
    parameter int OF_G = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic           cfg_din,
    input  logic [TAB-1:0] wr_f,
    input  logic [TAB-1:0] wr_g,
    input  logic           wdat,
    output logic [CW-1:0]  cfg,
    output logic           loaded
);
    // Shift, table write and loaded-flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            loaded <= 1'b0;
        end else if (cfg_en) begin
            cfg    <= {cfg_din, cfg[CW-1:1]};
            loaded <= 1'b1;
        end else begin
            for (int i = 0; i < TAB; i++) begin
                if (wr_f[i]) cfg[OF_F+i] <= wdat;
                if (wr_g[i]) cfg[OF_G+i] <= wdat;
            end
        end
    end
endmodule

// File: rtl/clb_fgen.sv
// One K-input function generator.
// Reads its truth table at the input address and, in RAM mode, raises a
// one-hot write strobe for that address. Assumes the table is stored outside.
module clb_fgen #(
    parameter int K   = 4,
    localparam int TAB = 1 << K
) (
    input  logic [TAB-1:0] table_bits,
    input  logic [K-1:0]   addr,
    input  logic           ram_mode,
    input  logic           we,
    output logic           rd,
    output logic [TAB-1:0] wstrobe
);
    // Table read.
    assign rd = table_bits[addr];

    genvar i;
    generate
        for (i = 0; i < TAB; i++) begin : g_strobe
            // Write strobe for entry i.
            assign wstrobe[i] = ram_mode & we & (addr == K'(i));
        end
    endgenerate
endmodule

// File: rtl/clb_store.sv
// One storage element: a flip-flop or a latch selected by configuration.
// Its clock polarity and its set/reset kind and value are also configured.
// Assumes ce and sr are already gated by the tile's loaded state.
module clb_store
    import clb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ce,
    input  logic    sr,
    input  logic    d,
    input  st_cfg_t sc,
    output logic    q
);
    logic clk_eff;
    logic asr;
    logic ff_q;
    logic lat_q;

    assign clk_eff = clk ^ sc.clk_inv;
    assign asr     = sr & sc.sr_async & ~sc.is_latch;

    // Edge-triggered path with optional asynchronous set/reset.
    always_ff @(posedge clk_eff or posedge asr) begin
        if (asr)         ff_q <= sc.sr_val;
        else if (!rst_n) ff_q <= 1'b0;
        else if (sr)     ff_q <= sc.sr_val;
        else if (ce)     ff_q <= d;
    end

    // Level-sensitive path, open while the effective clock is high.
    always_latch begin
        if (!rst_n)                     lat_q <= 1'b0;
        else if (sr && sc.sr_async)     lat_q <= sc.sr_val;
        else if (clk_eff && (sr || ce)) lat_q <= sr ? sc.sr_val : d;
    end

    // Output selection by mode.
    assign q = sc.is_latch ? lat_q : ff_q;
endmodule

// File: rtl/clb_tile.sv
// Logic block tile: F and G lookup tables (each usable as a 16x1 RAM), an H
// combiner and two configurable storage elements. All outputs stay at 0 until
// a serial configuration load has finished. Assumes a single clk domain.
module clb_tile
    import clb_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    input  logic [K-1:0] f_in,
    input  logic [K-1:0] g_in,
    input  logic         h1,
    input  logic         din,
    input  logic         we,
    input  logic         ce,
    input  logic         sr,
    output logic         f_out,
    output logic         g_out,
    output logic         h_out,
    output logic         xq,
    output logic         yq
);
    localparam int TAB   = 1 << K;
    localparam int OF_F  = 0;
    localparam int OF_G  = TAB;
    localparam int OF_H  = 2 * TAB;
    localparam int OF_RF = OF_H + H_TAB;
    localparam int OF_RG = OF_RF + 1;
    localparam int OF_SX = OF_RG + 1;
    localparam int CW    = OF_SX + 2 * ST_W;

    logic [CW-1:0]  cfg_q;
    logic           loaded;
    logic           valid;
    logic [TAB-1:0] wr_f;
    logic [TAB-1:0] wr_g;
    logic           f_raw;
    logic           g_raw;
    logic           h_raw;
    logic           we_g;
    logic           ce_g;
    logic           sr_g;
    logic [1:0]     st_q;

    // Tile is usable once loaded and not being reloaded.
    assign valid = loaded & ~cfg_en;
    assign we_g  = we & valid;
    assign ce_g  = ce & valid;
    assign sr_g  = sr & valid;

    clb_cfg_chain #(.CW(CW), .TAB(TAB), .OF_F(OF_F), .OF_G(OF_G)) u_chain (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .wr_f(wr_f), .wr_g(wr_g), .wdat(din), .cfg(cfg_q), .loaded(loaded)
    );

    clb_fgen #(.K(K)) u_fgen_f (
        .table_bits(cfg_q[OF_F +: TAB]), .addr(f_in), .ram_mode(cfg_q[OF_RF]),
        .we(we_g), .rd(f_raw), .wstrobe(wr_f)
    );

    clb_fgen #(.K(K)) u_fgen_g (
        .table_bits(cfg_q[OF_G +: TAB]), .addr(g_in), .ram_mode(cfg_q[OF_RG]),
        .we(we_g), .rd(g_raw), .wstrobe(wr_g)
    );

    // H combiner lookup, h1 as most significant index bit.
    assign h_raw = cfg_q[OF_H + int'({h1, g_raw, f_raw})];

    genvar s;
    generate
        for (s = 0; s < 2; s++) begin : g_st
            st_cfg_t sc;
            logic    d_sel;
            assign sc = st_cfg_t'(cfg_q[OF_SX + s*ST_W +: ST_W]);
            // Data source selection for this storage element.
            always_comb begin
                case (sc.dsel)
                    SEL_F:   d_sel = f_raw;
                    SEL_G:   d_sel = g_raw;
                    SEL_H:   d_sel = h_raw;
                    default: d_sel = din;
                endcase
            end
            clb_store u_st (
                .clk(clk), .rst_n(rst_n), .ce(ce_g), .sr(sr_g),
                .d(d_sel), .sc(sc), .q(st_q[s])
            );
        end
    endgenerate

    // Output gating by loaded state.
    assign f_out = f_raw & valid;
    assign g_out = g_raw & valid;
    assign h_out = h_raw & valid;
    assign xq    = st_q[0] & valid;
    assign yq    = st_q[1] & valid;
endmodule

// File: rtl/clb_tile_chk.sv
// Checker for clb_tile, bound to every instance.
// Assumes it sees the tile's ports plus the decoded mode bits of F and X.
module clb_tile_chk #(
    parameter int K = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_en,
    input logic         valid,
    input logic         ram_f,
    input logic         x_latch,
    input logic         x_inv,
    input logic         x_async,
    input logic         x_srval,
    input logic [K-1:0] f_in,
    input logic         din,
    input logic         we,
    input logic         ce,
    input logic         sr,
    input logic         f_out,
    input logic         g_out,
    input logic         h_out,
    input logic         xq,
    input logic         yq
);
    // R1
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> ({f_out, g_out, h_out, xq, yq} == 5'b0));

    // R4
    ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ram_f && we) |=> (cfg_en || !$stable(f_in) || f_out == $past(din)));

    // R9
    sync_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !x_latch && !x_inv && sr) |=> (cfg_en || xq == $past(x_srval)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !x_latch && !x_inv && !x_async && !sr && !ce)
        |=> (cfg_en || xq == $past(xq)));
endmodule

bind clb_tile clb_tile_chk #(.K(K)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .valid(valid),
    .ram_f(cfg_q[OF_RF]), .x_latch(cfg_q[OF_SX]), .x_inv(cfg_q[OF_SX+1]),
    .x_async(cfg_q[OF_SX+2]), .x_srval(cfg_q[OF_SX+3]),
    .f_in(f_in), .din(din), .we(we), .ce(ce), .sr(sr),
    .f_out(f_out), .g_out(g_out), .h_out(h_out), .xq(xq), .yq(yq)
);

// File: tb/clb_tile_tb.sv
module clb_tile_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic h1 = 1'b0, din = 1'b0, we = 1'b0, ce = 1'b0, sr = 1'b0;
    logic f_out, g_out, h_out, xq, yq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] ftab, gtab;
    logic [7:0]  htab;

    always #2.5 clk = ~clk;

    clb_tile u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .f_in(f_in), .g_in(g_in), .h1(h1), .din(din), .we(we), .ce(ce), .sr(sr),
        .f_out(f_out), .g_out(g_out), .h_out(h_out), .xq(xq), .yq(yq)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // storage field: {dsel[1:0], srval, async, inv, latch}
    function automatic logic [5:0] st(input logic [1:0] sel, input logic srv,
                                      input logic as, input logic inv, input logic lat);
        return {sel, srv, as, inv, lat};
    endfunction

    function automatic logic exp_f(); return ftab[f_in]; endfunction
    function automatic logic exp_g(); return gtab[g_in]; endfunction
    function automatic logic exp_h(); return htab[{h1, gtab[g_in], ftab[f_in]}]; endfunction

    task automatic hi_phase(); @(posedge clk); #1; endtask
    task automatic lo_phase(); @(negedge clk); #1; endtask

    task automatic load(input logic rf, input logic rg, input logic [5:0] sx, input logic [5:0] sy);
        logic [53:0] w;
        w = {sy, sx, rg, rf, htab, gtab, ftab};
        for (int i = 0; i < 54; i++) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_din = w[i];
            if (i == 30) begin
                #1;
                chk("R1 quiet f", f_out, 1'b0);
                chk("R1 quiet x", xq, 1'b0);
            end
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic rand_tables();
        ftab = 16'($urandom); gtab = 16'($urandom); htab = 8'($urandom);
    endtask

    task automatic rand_in();
        f_in = 4'($urandom); g_in = 4'($urandom); h1 = 1'($urandom);
    endtask

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic xe;
        void'($urandom(32'h5eed_c1b0));
        repeat (3) @(posedge clk);
        lo_phase();
        rst_n = 1'b1;
        // R12: reset state, nothing loaded yet
        chk("R12 f", f_out, 1'b0);
        chk("R12 g", g_out, 1'b0);
        chk("R12 h", h_out, 1'b0);
        chk("R12 x", xq, 1'b0);
        chk("R12 y", yq, 1'b0);

        // R2 R3 R11: random tables, data select sweep
        for (int sel = 0; sel < 4; sel++) begin
            rand_tables();
            load(1'b0, 1'b0, st(2'(sel), 1'b0, 1'b0, 1'b0, 1'b0),
                 st(2'((sel + 1) % 4), 1'b0, 1'b0, 1'b0, 1'b0));
            ce = 1'b1;
            for (int k = 0; k < 40; k++) begin
                hi_phase();
                rand_in();
                din = 1'($urandom);
                #1;
                chk("R2 f", f_out, exp_f());
                chk("R2 g", g_out, exp_g());
                chk("R3 h", h_out, exp_h());
                case (sel)
                    0: xe = exp_f();
                    1: xe = exp_g();
                    2: xe = exp_h();
                    default: xe = din;
                endcase
                hi_phase();
                chk("R11 sel", xq, xe);
            end
            ce = 1'b0;
        end

        // R4 R5: F as RAM, G logic, random writes
        rand_tables();
        load(1'b1, 1'b0, st(2'd3, 1'b0, 1'b0, 1'b0, 1'b0), st(2'd3, 1'b0, 1'b0, 1'b0, 1'b0));
        for (int k = 0; k < 80; k++) begin
            hi_phase();
            rand_in();
            din = 1'($urandom);
            we = 1'($urandom);
            lo_phase();
            chk("R4 pre", f_out, exp_f());
            hi_phase();
            if (we) ftab[f_in] = din;
            chk("R4 rdw", f_out, exp_f());
            chk("R5 g kept", g_out, exp_g());
        end
        we = 1'b0;

        // R6 R7 R9: X rising flop, Y falling flop, both sync sr to 0
        load(1'b0, 1'b0, st(2'd3, 1'b0, 1'b0, 1'b0, 1'b0), st(2'd3, 1'b0, 1'b0, 1'b1, 1'b0));
        hi_phase(); din = 1'b0; ce = 1'b1;
        hi_phase(); hi_phase();
        din = 1'b1;
        lo_phase();
        chk("R6 no early", xq, 1'b0);
        chk("R7 neg edge", yq, 1'b1);
        hi_phase();
        chk("R6 capture", xq, 1'b1);
        ce = 1'b0; din = 1'b0;
        lo_phase();
        chk("R7 hold ce0", yq, 1'b1);
        hi_phase();
        chk("R6 hold ce0", xq, 1'b1);
        sr = 1'b1; ce = 1'b1; din = 1'b1;
        #1;
        chk("R9 waits edge", xq, 1'b1);
        lo_phase();
        chk("R9 y priority", yq, 1'b0);
        hi_phase();
        chk("R9 x priority", xq, 1'b0);
        sr = 1'b0;

        // R8 R9 R10: X async flop set to 1, Y rising latch sync set to 1
        load(1'b0, 1'b0, st(2'd3, 1'b1, 1'b1, 1'b0, 1'b0), st(2'd3, 1'b1, 1'b0, 1'b0, 1'b1));
        hi_phase(); din = 1'b0; ce = 1'b1;
        hi_phase();
        chk("R8 open low", yq, 1'b0);
        chk("R6 x low", xq, 1'b0);
        lo_phase(); din = 1'b1; #0.5;
        chk("R8 closed", yq, 1'b0);
        hi_phase();
        chk("R8 opened", yq, 1'b1);
        din = 1'b0; #0.5;
        chk("R8 transparent", yq, 1'b0);
        hi_phase();
        chk("R6 x re-low", xq, 1'b0);
        ce = 1'b0;
        lo_phase();
        sr = 1'b1; #0.5;
        chk("R10 async now", xq, 1'b1);
        chk("R9 latch waits", yq, 1'b0);
        hi_phase();
        chk("R9 latch set", yq, 1'b1);
        sr = 1'b0;

        // R12: reset after a load clears outputs and loaded state
        htab = 8'hFF;
        load(1'b0, 1'b0, st(2'd3, 1'b0, 1'b0, 1'b0, 1'b0), st(2'd3, 1'b0, 1'b0, 1'b0, 1'b0));
        #1;
        chk("R3 h all ones", h_out, 1'b1);
        lo_phase(); rst_n = 1'b0;
        hi_phase(); hi_phase();
        rst_n = 1'b1;
        lo_phase();
        chk("R12 h after reset", h_out, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule